// File: doc/BRIEF.md
# TFT Panel Power Sequencer

This block switches a TFT panel on and off in a safe order. It drives three enables: the panel supply, the data/control signal group, and the backlight. On power-up it raises them in that order. On power-down it drops them in the reverse order. A programmable wait separates each step. After every power-down, a minimum off-time must pass before the supply may come back.

Software configures the block through a small register port with two words. The configuration word holds the interface enable, the active level of the supply and backlight pins, and five 4-bit wait codes. It takes exactly one write after reset and then freezes, so a later stray write cannot shorten the waits. The control word holds a single run bit: setting it requests power-up and clearing it requests power-down. Waits count whole steps of a 10 ms tick or a 100 ms tick. Both ticks come from a clock-cycle prescaler whose length is a parameter.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset the configuration word (address 0) reads 0xE00B3723 and the control word (address 1) reads 0. With these values every panel pin is inactive, `phase_o` is 0 and `busy_o` is 0.
- R2: The configuration word takes only the first write after reset. Any later write leaves its read-back value unchanged. Its fields are: enable in bit 31, supply polarity in bit 30, backlight polarity in bit 29, zero in bits 28:20, the lockout code in 19:16, the signal-off code in 15:12, the backlight-off code in 11:8, the backlight-on code in 7:4 and the signal-on code in 3:0.
- R3: Power-up raises the supply first. The signal group follows (c+1)·T clock cycles later, where c is the code in bits 3:0 and T is `TICKS_10MS`. The backlight follows (c+1)·10·T cycles after that, where c is the code in bits 7:4.
- R4: Power-down drops the backlight first. The signal group drops (c+1)·10·T cycles later, where c is the code in bits 11:8. The supply drops (c+1)·T cycles after that, where c is the code in bits 15:12.
- R5: After the supply drops, it cannot rise again for (c+1)·10·T cycles, where c is the code in bits 19:16. A run request that arrives during this lockout is held. The supply then rises exactly when the lockout ends.
- R6: While the enable bit is 0, all three panel outputs stay inactive and the run bit reads 0, even after 1 is written to it.
- R7: A polarity bit of 1 makes its pin active high. A polarity bit of 0 makes it active low, so the pin idles at 1 and drives 0 when on. The signal-group enable is always active high.
- R8: Clearing the run bit before power-up finishes reverses the sequence from the stage already reached. If it is cleared while waiting for the signal group, the signal group never asserts and the supply drops after the signal-off wait. If it is cleared while waiting for the backlight, the backlight never asserts and the signal group drops after the backlight-off wait.
- R9: `phase_o` encodes off=0, lockout=1, ramping up=2, on=3, ramping down=4. `busy_o` is 1 exactly in phases 1, 2 and 4.
- R10: Bit 0 of the control word reads back the last value written to it while the interface is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select for read and write: 0 configuration, 1 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| panel_sup_o | output | 1 | Panel supply enable, level set by polarity |
| panel_sig_o | output | 1 | Data/control signal group enable, active high |
| panel_bl_o | output | 1 | Backlight enable, level set by polarity |
| phase_o | output | 3 | Current phase code |
| busy_o | output | 1 | High while a timed stage is running |

## Verification
The bench sweeps sixteen configurations. Each one gives the signal-on wait all sixteen codes and sets the other four waits to different codes. A swapped field, a 10 ms/100 ms mix-up, or an off-by-one step count therefore shows up as a wrong interval between pin edges. Every configuration also places a run request inside the lockout, which separates a held request from one that is dropped or started early. The bench also clears the run bit in each of the two power-up stages, runs the polarity-low case and the disabled-interface case, and writes the configuration word a second time. These tests tell apart a correct reversal, polarity handling, enable gating and write lock from their faulty variants.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_LOCK = 3'd1,
    PH_UP   = 3'd2,
    PH_ON   = 3'd3,
    PH_DOWN = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_UP_SUP,
    ST_UP_SIG,
    ST_ON,
    ST_DN_BL,
    ST_DN_SIG,
    ST_LOCK
  } seq_state_e;

  typedef struct packed {
    logic              en;
    logic              sup_pol;
    logic              bl_pol;
    logic [CODE_W-1:0] c_lock;
    logic [CODE_W-1:0] c_sig_off;
    logic [CODE_W-1:0] c_bl_off;
    logic [CODE_W-1:0] c_bl_on;
    logic [CODE_W-1:0] c_sig_on;
  } cfg_t;

endpackage

// File: rtl/pps_timebase.sv
module pps_timebase #(
  parameter int TICKS_10MS = 270000,
  parameter int COARSE_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic fine_tick,
  output logic coarse_tick
);
  localparam int FW = (TICKS_10MS > 1) ? $clog2(TICKS_10MS) : 1;
  localparam int CW = (COARSE_DIV > 1) ? $clog2(COARSE_DIV) : 1;
  localparam logic [FW-1:0] FINE_MAX   = FW'(TICKS_10MS - 1);
  localparam logic [CW-1:0] COARSE_MAX = CW'(COARSE_DIV - 1);

  logic [FW-1:0] fine_q, fine_d;
  logic [CW-1:0] coarse_q, coarse_d;

  assign fine_tick   = (fine_q == FINE_MAX);
  assign coarse_tick = fine_tick && (coarse_q == COARSE_MAX);

  always_comb begin
    fine_d   = fine_q;
    coarse_d = coarse_q;
    if (clr) begin
      fine_d   = '0;
      coarse_d = '0;
    end else if (fine_tick) begin
      fine_d   = '0;
      coarse_d = (coarse_q == COARSE_MAX) ? '0 : coarse_q + CW'(1);
    end else begin
      fine_d   = fine_q + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else begin
      fine_q   <= fine_d;
      coarse_q <= coarse_d;
    end
  end
endmodule

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output cfg_t          cfg,
  output logic          cfg_locked,
  output logic          run
);
  localparam int PAD_W = DW - 3 - 5 * CODE_W;
  localparam cfg_t CFG_RST = '{en: 1'b1, sup_pol: 1'b1, bl_pol: 1'b1,
                               c_lock: 4'd11, c_sig_off: 4'd3, c_bl_off: 4'd7,
                               c_bl_on: 4'd2, c_sig_on: 4'd3};

  cfg_t cfg_q, cfg_d;
  logic lock_q, lock_d;
  logic run_q, run_d;
  logic cfg_we, ctl_we;

  assign cfg_we = reg_wr && !reg_addr && !lock_q;
  assign ctl_we = reg_wr && reg_addr;

  always_comb begin
    cfg_d  = cfg_q;
    lock_d = lock_q;
    if (cfg_we) begin
      cfg_d.en        = reg_wdata[DW-1];
      cfg_d.sup_pol   = reg_wdata[DW-2];
      cfg_d.bl_pol    = reg_wdata[DW-3];
      cfg_d.c_lock    = reg_wdata[5*CODE_W-1:4*CODE_W];
      cfg_d.c_sig_off = reg_wdata[4*CODE_W-1:3*CODE_W];
      cfg_d.c_bl_off  = reg_wdata[3*CODE_W-1:2*CODE_W];
      cfg_d.c_bl_on   = reg_wdata[2*CODE_W-1:CODE_W];
      cfg_d.c_sig_on  = reg_wdata[CODE_W-1:0];
      lock_d          = 1'b1;
    end
  end

  always_comb begin
    run_d = run_q;
    if (!cfg_q.en)   run_d = 1'b0;
    else if (ctl_we) run_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      lock_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
      run_q  <= run_d;
    end
  end

  always_comb begin
    if (reg_addr) reg_rdata = {{(DW-1){1'b0}}, run_q};
    else          reg_rdata = {cfg_q.en, cfg_q.sup_pol, cfg_q.bl_pol, {PAD_W{1'b0}},
                               cfg_q.c_lock, cfg_q.c_sig_off, cfg_q.c_bl_off,
                               cfg_q.c_bl_on, cfg_q.c_sig_on};
  end

  assign cfg        = cfg_q;
  assign cfg_locked = lock_q;
  assign run        = run_q;
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cfg_t       cfg,
  input  logic       run,
  input  logic       fine_tick,
  input  logic       coarse_tick,
  output logic       tb_clr,
  output logic       sup_on,
  output logic       sig_on,
  output logic       bl_on,
  output logic [2:0] phase,
  output logic       busy
);
  seq_state_e        st_q, st_d;
  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic [CODE_W-1:0] code;
  logic              use_coarse, step, done;
  phase_e            ph;

  always_comb begin
    code       = '0;
    use_coarse = 1'b0;
    unique case (st_q)
      ST_UP_SUP: code = cfg.c_sig_on;
      ST_UP_SIG: begin code = cfg.c_bl_on;  use_coarse = 1'b1; end
      ST_DN_BL:  begin code = cfg.c_bl_off; use_coarse = 1'b1; end
      ST_DN_SIG: code = cfg.c_sig_off;
      ST_LOCK:   begin code = cfg.c_lock;   use_coarse = 1'b1; end
      default:   code = '0;
    endcase
  end

  assign step = use_coarse ? coarse_tick : fine_tick;
  assign done = step && (cnt_q == code);

  always_comb begin
    st_d = st_q;
    if (!cfg.en) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:    if (run) st_d = ST_UP_SUP;
        ST_UP_SUP: if (!run) st_d = ST_DN_SIG; else if (done) st_d = ST_UP_SIG;
        ST_UP_SIG: if (!run) st_d = ST_DN_BL;  else if (done) st_d = ST_ON;
        ST_ON:     if (!run) st_d = ST_DN_BL;
        ST_DN_BL:  if (done) st_d = ST_DN_SIG;
        ST_DN_SIG: if (done) st_d = ST_LOCK;
        ST_LOCK:   if (done) st_d = run ? ST_UP_SUP : ST_OFF;
        default:   st_d = ST_OFF;
      endcase
    end
  end

  assign tb_clr = (st_d != st_q);

  always_comb begin
    cnt_d = cnt_q;
    if (tb_clr)    cnt_d = '0;
    else if (step) cnt_d = cnt_q + CODE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    sup_on = 1'b0;
    sig_on = 1'b0;
    bl_on  = 1'b0;
    ph     = PH_OFF;
    unique case (st_q)
      ST_UP_SUP: begin sup_on = 1'b1; ph = PH_UP; end
      ST_UP_SIG: begin sup_on = 1'b1; sig_on = 1'b1; ph = PH_UP; end
      ST_ON:     begin sup_on = 1'b1; sig_on = 1'b1; bl_on = 1'b1; ph = PH_ON; end
      ST_DN_BL:  begin sup_on = 1'b1; sig_on = 1'b1; ph = PH_DOWN; end
      ST_DN_SIG: begin sup_on = 1'b1; ph = PH_DOWN; end
      ST_LOCK:   ph = PH_LOCK;
      default:   ph = PH_OFF;
    endcase
  end

  assign phase = ph;
  assign busy  = (ph == PH_UP) || (ph == PH_DOWN) || (ph == PH_LOCK);
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int TICKS_10MS = 270000,
  parameter int COARSE_DIV = 10,
  parameter int DW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          panel_sup_o,
  output logic          panel_sig_o,
  output logic          panel_bl_o,
  output logic [2:0]    phase_o,
  output logic          busy_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  cfg_t       cfg;
  logic       cfg_locked, run;
  logic       tb_clr, fine_tick, coarse_tick;
  logic       sup_on, sig_on, bl_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  pps_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg),
    .cfg_locked(cfg_locked), .run(run)
  );

  pps_timebase #(.TICKS_10MS(TICKS_10MS), .COARSE_DIV(COARSE_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n_s), .clr(tb_clr),
    .fine_tick(fine_tick), .coarse_tick(coarse_tick)
  );

  pps_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .cfg(cfg), .run(run),
    .fine_tick(fine_tick), .coarse_tick(coarse_tick), .tb_clr(tb_clr),
    .sup_on(sup_on), .sig_on(sig_on), .bl_on(bl_on),
    .phase(phase_o), .busy(busy_o)
  );

  assign panel_sup_o = sup_on ~^ cfg.sup_pol;
  assign panel_sig_o = sig_on;
  assign panel_bl_o  = bl_on ~^ cfg.bl_pol;
endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk
  import pps_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input cfg_t       cfg,
  input logic       cfg_locked,
  input logic       run,
  input logic       sup_on,
  input logic       sig_on,
  input logic       bl_on,
  input logic [2:0] phase,
  input logic       busy
);
  p_frozen_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> $stable(cfg));

  p_bl_needs_sig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bl_on |-> sig_on);

  p_sig_needs_sup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sig_on |-> sup_on);

  p_lockout_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |-> !sup_on);

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> (!sup_on && !sig_on && !bl_on && !run));

  p_stop_kills_bl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |=> !bl_on);

  p_phase_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd4);

  p_busy_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (phase != 3'd0 && phase != 3'd3));
endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .cfg(cfg), .cfg_locked(cfg_locked), .run(run),
  .sup_on(sup_on), .sig_on(sig_on), .bl_on(bl_on), .phase(phase_o), .busy(busy_o)
);

// File: tb/panel_pwr_seq_tb.sv
`timescale 1ns/1ps
module panel_pwr_seq_tb;
  localparam int T  = 4;
  localparam int CT = 10 * T;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        panel_sup_o, panel_sig_o, panel_bl_o, busy_o;
  logic [2:0]  phase_o;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  logic pol_s = 1'b1, pol_b = 1'b1;
  logic sig_seen = 1'b0, bl_seen = 1'b0;

  panel_pwr_seq #(.TICKS_10MS(T), .COARSE_DIV(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .panel_sup_o(panel_sup_o),
    .panel_sig_o(panel_sig_o), .panel_bl_o(panel_bl_o), .phase_o(phase_o),
    .busy_o(busy_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic act(input int w);
    if (w == 0)      return panel_sup_o ~^ pol_s;
    else if (w == 1) return panel_sig_o;
    else             return panel_bl_o ~^ pol_b;
  endfunction

  always @(negedge clk) begin
    if (act(1)) sig_seen = 1'b1;
    if (act(2)) bl_seen = 1'b1;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  task automatic chk(input logic ok, input string req, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic logic [31:0] mk(input logic en, input logic ps, input logic pb,
      input int c6, input int c5, input int c4, input int c3, input int c2);
    return {en, ps, pb, 9'd0, 4'(c6), 4'(c5), 4'(c4), 4'(c3), 4'(c2)};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_act(input int w, input logic v, output longint t);
    int n = 0;
    while (act(w) !== v && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(1'b0, "timeout", w, v);
    t = cyc;
  endtask

  logic [31:0] d;
  longint ta, tb, tc, td, te, tf, tg;

  initial begin
    do_reset();
    // R1: reset state
    rd(1'b0, d); chk(d == 32'hE00B3723, "R1 cfg reset", d, 32'hE00B3723);
    rd(1'b1, d); chk(d == 32'h0, "R1 ctl reset", d, 0);
    chk({panel_sup_o, panel_sig_o, panel_bl_o} == 3'b000, "R1 pins idle",
        {panel_sup_o, panel_sig_o, panel_bl_o}, 0);
    chk(phase_o == 3'd0 && busy_o == 1'b0, "R1 phase idle", phase_o, 0);

    // Sweep over the signal-on code, with the other codes varied
    for (int i = 0; i < 16; i++) begin
      int c2 = i, c3 = i % 4, c4 = (i + 1) % 4, c5 = 15 - i, c6 = i % 3;
      do_reset();
      pol_s = 1'b1; pol_b = 1'b1;
      wr(1'b0, mk(1'b1, 1'b1, 1'b1, c6, c5, c4, c3, c2));
      if (i == 0) begin
        wr(1'b0, mk(1'b1, 1'b0, 1'b0, 9, 9, 9, 9, 9));
        rd(1'b0, d);
        chk(d == mk(1'b1, 1'b1, 1'b1, c6, c5, c4, c3, c2), "R2 write once", d,
            mk(1'b1, 1'b1, 1'b1, c6, c5, c4, c3, c2));
      end
      wr(1'b1, 32'h1);
      rd(1'b1, d); chk(d == 32'h1, "R10 run readback", d, 1);
      wait_act(0, 1'b1, ta);
      chk(phase_o == 3'd2 && busy_o, "R9 ramp up phase", phase_o, 2);
      wait_act(1, 1'b1, tb);
      chk(tb - ta == longint'((c2 + 1) * T), "R3 signal-on wait", tb - ta, (c2 + 1) * T);
      wait_act(2, 1'b1, tc);
      chk(tc - tb == longint'((c3 + 1) * CT), "R3 backlight-on wait", tc - tb, (c3 + 1) * CT);
      chk(phase_o == 3'd3 && !busy_o, "R9 on phase", phase_o, 3);
      wr(1'b1, 32'h0);
      wait_act(2, 1'b0, td);
      chk(phase_o == 3'd4 && busy_o, "R9 ramp down phase", phase_o, 4);
      wait_act(1, 1'b0, te);
      chk(te - td == longint'((c4 + 1) * CT), "R4 backlight-off wait", te - td, (c4 + 1) * CT);
      wait_act(0, 1'b0, tf);
      chk(tf - te == longint'((c5 + 1) * T), "R4 signal-off wait", tf - te, (c5 + 1) * T);
      chk(phase_o == 3'd1 && busy_o, "R9 lockout phase", phase_o, 1);
      wr(1'b1, 32'h1);
      chk(act(0) == 1'b0, "R5 held during lockout", act(0), 0);
      wait_act(0, 1'b1, tg);
      chk(tg - tf == longint'((c6 + 1) * CT), "R5 lockout length", tg - tf, (c6 + 1) * CT);
    end

    // R8: stop while waiting for the backlight
    do_reset();
    wr(1'b0, mk(1'b1, 1'b1, 1'b1, 0, 2, 0, 1, 1));
    wr(1'b1, 32'h1);
    wait_act(1, 1'b1, ta);
    bl_seen = 1'b0;
    wr(1'b1, 32'h0);
    wait_act(1, 1'b0, tb);
    wait_act(0, 1'b0, tc);
    chk(bl_seen == 1'b0, "R8 backlight never on", bl_seen, 0);
    chk(tc - tb == longint'(3 * T), "R8 supply drop after signal-off wait", tc - tb, 3 * T);

    // R8: stop while waiting for the signal group
    sig_seen = 1'b0;
    wr(1'b1, 32'h1);
    wait_act(0, 1'b1, ta);
    wr(1'b1, 32'h0);
    wait_act(0, 1'b0, tb);
    chk(sig_seen == 1'b0, "R8 signal never on", sig_seen, 0);
    chk(tb - ta == longint'(3 * T + 3), "R8 supply drop timing", tb - ta, 3 * T + 3);

    // R7: active-low polarity
    do_reset();
    wr(1'b0, mk(1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 0));
    pol_s = 1'b0; pol_b = 1'b0;
    chk(panel_sup_o == 1'b1 && panel_bl_o == 1'b1, "R7 idle high",
        {panel_sup_o, panel_bl_o}, 3);
    wr(1'b1, 32'h1);
    wait_act(2, 1'b1, tc);
    chk(panel_sup_o == 1'b0 && panel_bl_o == 1'b0 && panel_sig_o == 1'b1, "R7 on levels",
        {panel_sup_o, panel_sig_o, panel_bl_o}, 2);

    // R6: interface disabled
    do_reset();
    pol_s = 1'b1; pol_b = 1'b1;
    wr(1'b0, mk(1'b0, 1'b1, 1'b1, 0, 0, 0, 0, 0));
    wr(1'b1, 32'h1);
    rd(1'b1, d); chk(d == 32'h0, "R6 run reads 0", d, 0);
    sig_seen = 1'b0; bl_seen = 1'b0;
    repeat (100) @(negedge clk);
    chk({panel_sup_o, panel_sig_o, panel_bl_o} == 3'b000 && !sig_seen && !bl_seen,
        "R6 pins inactive", {panel_sup_o, panel_sig_o, panel_bl_o}, 0);
    chk(phase_o == 3'd0, "R6 phase off", phase_o, 0);

    finish_run();
  end
endmodule